// File: doc/BRIEF.md
# Legacy VGA Address Router

This block picks the destination of every access that reaches a bridge from one of three source ports: the host bus, the hub link or the on-chip graphics engine. It has a single request channel. Each request names its source, whether it is a memory or an I/O access, and its address. The block returns a target code and an accept flag on a result channel, in the order the requests arrived. One address map serves all three sources. Configuration inputs give the top of system memory and the graphics aperture window. A single steering bit decides whether the legacy display windows go to the on-chip graphics device or out over the hub.

The legacy display windows come in two kinds. The first is the memory window from A0000h to BFFFFh. The second is the I/O port groups 3B0h–3BBh and 3C0h–3DFh. Ports are compared on the low ten address bits only, so every ISA alias of a display port matches. Port 3BFh always goes to the hub, whatever the steering bit says. The hub source is filtered. Its I/O accesses are never claimed. Its memory accesses are claimed only when they land in system memory or graphics memory.

Results are registered. A result can be read one cycle after its request is taken. Up to four results may wait to be read, and the request channel stalls while all four slots are full.

Top module: `bridge_addr_router`

## Requirements
- R1: For sources host (code 0) and graphics (code 2), a memory access from A0000h through BFFFFh is accepted with target IGD (code 3) when cfgVgaToGfx is 1, and with target HUB (code 4) when it is 0. This window has priority over the system memory and aperture checks.
- R2: An I/O access whose address bits [9:0] lie in 3B0h–3BBh or 3C0h–3DFh (ends included) follows the same cfgVgaToGfx steering as R1. Address bits above bit 9 play no part in the match.
- R3: For sources 0 and 2, an I/O access outside the R2 ranges is accepted with target HUB (code 4).
- R4: For sources 0 and 2, an I/O access with address bits [9:0] equal to 3BFh is accepted with target HUB, whatever cfgVgaToGfx is.
- R5: Every I/O access from the hub source (code 1) is rejected: rspAccept is 0 and the target is NONE (code 0).
- R6: A hub-source memory access is accepted only when its mapped target is SYSMEM (code 1), GFXMEM (code 2) or IGD (code 3). Otherwise it is rejected with target NONE. A rejected result always carries target NONE.
- R7: Outside the R1 window, a memory address below cfgTopOfMem maps to SYSMEM. Failing that, an address in cfgApBase..cfgApLimit (ends included) maps to GFXMEM. Any other address maps to HUB.
- R8: Sources 0 and 2 see the same map. Source code 3 is rejected with target NONE.
- R9: A request is taken at a clock edge where reqValid and reqReady are both 1. Its result shows up with rspValid high right after that edge. Results come out in request order.
- R10: At most four results are pending. reqReady is 0 exactly while four results are pending, and no request is lost or duplicated.
- R11: While rspValid is 1 and rspReady is 0, the result on the output holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqSrc | input | 2 | Source: 0 host, 1 hub, 2 graphics, 3 reserved |
| reqIsIo | input | 1 | 1 for I/O access, 0 for memory |
| reqAddr | input | ADDR_W | Access address |
| cfgVgaToGfx | input | 1 | 1 steers legacy display windows to on-chip graphics, 0 to hub |
| cfgTopOfMem | input | ADDR_W | First address above system memory |
| cfgApBase | input | ADDR_W | Lowest aperture address |
| cfgApLimit | input | ADDR_W | Highest aperture address |
| rspValid | output | 1 | Result present |
| rspReady | input | 1 | Result taken |
| rspTarget | output | 3 | 0 none, 1 sysmem, 2 gfxmem, 3 IGD, 4 hub |
| rspAccept | output | 1 | 1 when the access is claimed |

## Verification
Host memory addresses are placed on each side of every window edge: 9FFFFh/A0000h, BFFFFh/C0000h, top of memory, and both aperture bounds. This separates window priority from off-by-one errors. The I/O stimulus covers the ends of both display port groups, 3BCh and 3BFh, the ports just outside each group, and high-bit aliases. Each of these runs with both steering values, which tells a real range match apart from one that ignores the steering bit or decodes too many address bits. The same addresses are replayed from the hub, graphics and reserved sources to separate the source filter from the map. A long run with the result channel held off fills all four slots, which shows the stall, the held output and that ordering survives.

// File: rtl/bridge_route_pkg.sv
`timescale 1ns/1ps
package bridge_route_pkg;

  parameter int unsigned QUEUE_DEPTH = 4;
  localparam int unsigned QPTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int unsigned QCNT_W = $clog2(QUEUE_DEPTH + 1);

  localparam int unsigned IO_DECODE_W = 10;
  localparam logic [IO_DECODE_W-1:0] MONO_PORT_LO  = 10'h3B0;
  localparam logic [IO_DECODE_W-1:0] MONO_PORT_HI  = 10'h3BB;
  localparam logic [IO_DECODE_W-1:0] COLOR_PORT_LO = 10'h3C0;
  localparam logic [IO_DECODE_W-1:0] COLOR_PORT_HI = 10'h3DF;
  localparam logic [IO_DECODE_W-1:0] PINNED_HUB_PORT = 10'h3BF;

  localparam logic [19:0] DISP_MEM_LO = 20'hA0000;
  localparam logic [19:0] DISP_MEM_HI = 20'hBFFFF;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_SYSMEM = 3'd1,
    TGT_GFXMEM = 3'd2,
    TGT_IGD    = 3'd3,
    TGT_HUB    = 3'd4
  } target_e;

  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_HUB  = 2'd1,
    SRC_GFX  = 2'd2,
    SRC_RSVD = 2'd3
  } source_e;

  typedef struct packed {
    target_e target;
    logic    accept;
  } route_result_t;

  typedef struct packed {
    logic              push;
    logic              pop;
    logic [QPTR_W-1:0] wrIdx;
    logic [QPTR_W-1:0] rdIdx;
  } route_strobe_t;

endpackage

// File: rtl/route_flow_ctrl.sv
`timescale 1ns/1ps
module route_flow_ctrl
  import bridge_route_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          rspReady,
  output logic          reqReady,
  output logic          rspValid,
  output route_strobe_t stb
);

  localparam logic [QCNT_W-1:0] FULL_CNT = QCNT_W'(QUEUE_DEPTH);
  localparam logic [QPTR_W-1:0] LAST_IDX = QPTR_W'(QUEUE_DEPTH - 1);

  logic [QCNT_W-1:0] pendCnt;
  logic [QPTR_W-1:0] wrPtr;
  logic [QPTR_W-1:0] rdPtr;
  logic              takeReq;
  logic              giveRsp;

  assign reqReady = (pendCnt != FULL_CNT);
  assign rspValid = (pendCnt != '0);
  assign takeReq  = reqValid && reqReady;
  assign giveRsp  = rspValid && rspReady;

  always_comb begin
    stb.push  = takeReq;
    stb.pop   = giveRsp;
    stb.wrIdx = wrPtr;
    stb.rdIdx = rdPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (takeReq) begin
      wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (giveRsp) begin
      rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else begin
      unique case ({takeReq, giveRsp})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= FULL_CNT); // R10

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == FULL_CNT && !rspReady) |=> (pendCnt == FULL_CNT && !reqReady)); // R10

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |=> rspValid); // R9

  AST_PTR_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == '0) |-> (wrPtr == rdPtr)); // R9

endmodule

// File: rtl/route_decode_dp.sv
`timescale 1ns/1ps
module route_decode_dp
  import bridge_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  route_strobe_t     stb,
  input  logic [1:0]        reqSrc,
  input  logic              reqIsIo,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cfgVgaToGfx,
  input  logic [ADDR_W-1:0] cfgTopOfMem,
  input  logic [ADDR_W-1:0] cfgApBase,
  input  logic [ADDR_W-1:0] cfgApLimit,
  output target_e           rspTarget,
  output logic              rspAccept
);

  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(DISP_MEM_LO);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(DISP_MEM_HI);

  logic [IO_DECODE_W-1:0] portLow;
  logic          portInDisp;
  logic          portPinned;
  logic          memInDisp;
  logic          memInSys;
  logic          memInAper;
  target_e       dispTarget;
  target_e       mapTarget;
  logic          claim;
  source_e       srcKind;
  route_result_t decRes;
  route_result_t slotQ [QUEUE_DEPTH];

  assign srcKind = source_e'(reqSrc);
  assign portLow = reqAddr[IO_DECODE_W-1:0];

  // Port match on the low ten bits only, so aliases above bit 9 all hit.
  always_comb begin
    portPinned = (portLow == PINNED_HUB_PORT);
    portInDisp = ((portLow >= MONO_PORT_LO) && (portLow <= MONO_PORT_HI)) ||
                 ((portLow >= COLOR_PORT_LO) && (portLow <= COLOR_PORT_HI));
  end

  always_comb begin
    memInDisp = (reqAddr >= WIN_LO) && (reqAddr <= WIN_HI);
    memInSys  = (reqAddr < cfgTopOfMem);
    memInAper = (reqAddr >= cfgApBase) && (reqAddr <= cfgApLimit);
  end

  assign dispTarget = cfgVgaToGfx ? TGT_IGD : TGT_HUB;

  // One map shared by every source.
  always_comb begin
    if (reqIsIo) begin
      if (portPinned)      mapTarget = TGT_HUB;
      else if (portInDisp) mapTarget = dispTarget;
      else                 mapTarget = TGT_HUB;
    end else begin
      if (memInDisp)       mapTarget = dispTarget;
      else if (memInSys)   mapTarget = TGT_SYSMEM;
      else if (memInAper)  mapTarget = TGT_GFXMEM;
      else                 mapTarget = TGT_HUB;
    end
  end

  // Source filter on top of the map.
  always_comb begin
    unique case (srcKind)
      SRC_HOST, SRC_GFX: claim = 1'b1;
      SRC_HUB:           claim = !reqIsIo &&
                                 ((mapTarget == TGT_SYSMEM) ||
                                  (mapTarget == TGT_GFXMEM) ||
                                  (mapTarget == TGT_IGD));
      default:           claim = 1'b0;
    endcase
    decRes.accept = claim;
    decRes.target = claim ? mapTarget : TGT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < QUEUE_DEPTH; i++) begin
        slotQ[i] <= '{target: TGT_NONE, accept: 1'b0};
      end
    end else if (stb.push) begin
      slotQ[stb.wrIdx] <= decRes;
    end
  end

  assign rspTarget = slotQ[stb.rdIdx].target;
  assign rspAccept = slotQ[stb.rdIdx].accept;

  AST_HUB_IO_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && reqIsIo && srcKind == SRC_HUB) |-> (!decRes.accept && decRes.target == TGT_NONE)); // R5

  AST_PINNED_PORT_HUB: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && reqIsIo && portPinned && (srcKind == SRC_HOST || srcKind == SRC_GFX))
      |-> (decRes.accept && decRes.target == TGT_HUB)); // R4

  AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && srcKind == SRC_RSVD) |-> !decRes.accept); // R8

  AST_HUB_MEM_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !reqIsIo && srcKind == SRC_HUB && decRes.accept)
      |-> (decRes.target != TGT_HUB && decRes.target != TGT_NONE)); // R6

endmodule

// File: rtl/bridge_addr_router.sv
`timescale 1ns/1ps
module bridge_addr_router
  import bridge_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqSrc,
  input  logic              reqIsIo,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cfgVgaToGfx,
  input  logic [ADDR_W-1:0] cfgTopOfMem,
  input  logic [ADDR_W-1:0] cfgApBase,
  input  logic [ADDR_W-1:0] cfgApLimit,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [2:0]        rspTarget,
  output logic              rspAccept
);

  route_strobe_t stb;
  target_e       headTarget;

  route_flow_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .stb      (stb)
  );

  route_decode_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqSrc      (reqSrc),
    .reqIsIo     (reqIsIo),
    .reqAddr     (reqAddr),
    .cfgVgaToGfx (cfgVgaToGfx),
    .cfgTopOfMem (cfgTopOfMem),
    .cfgApBase   (cfgApBase),
    .cfgApLimit  (cfgApLimit),
    .rspTarget   (headTarget),
    .rspAccept   (rspAccept)
  );

  assign rspTarget = headTarget;

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspTarget) && $stable(rspAccept))); // R11

  AST_REJECT_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAccept) |-> (rspTarget == 3'd0)); // R6

endmodule

// File: tb/bridge_addr_router_test.sv
`timescale 1ns/1ps
module bridge_addr_router_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TOM     = 32'h0400_0000;
  localparam logic [31:0] AP_BASE = 32'hD000_0000;
  localparam logic [31:0] AP_LIM  = 32'hD3FF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqSrc = 2'd0;
  logic        reqIsIo = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        cfgVgaToGfx = 1'b1;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [2:0]  rspTarget;
  logic        rspAccept;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit hold = 1'b0;
  bit done = 1'b0;

  logic [2:0] expTgt[$];
  logic       expAcc[$];
  string      expTag[$];

  bridge_addr_router #(.ADDR_W(32)) uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqSrc(reqSrc), .reqIsIo(reqIsIo), .reqAddr(reqAddr),
    .cfgVgaToGfx(cfgVgaToGfx), .cfgTopOfMem(TOM),
    .cfgApBase(AP_BASE), .cfgApLimit(AP_LIM),
    .rspValid(rspValid), .rspReady(rspReady),
    .rspTarget(rspTarget), .rspAccept(rspAccept)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    cyc++;
    rspReady = !hold && (cyc % 3 != 2);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] src, input logic io, input logic [31:0] a,
                                input logic steer, output logic [2:0] t, output logic acc);
    logic [9:0] p;
    logic [2:0] m;
    p = a[9:0];
    if (io) begin
      if (p == 10'h3BF) m = 3'd4;
      else if ((p >= 10'h3B0 && p <= 10'h3BB) || (p >= 10'h3C0 && p <= 10'h3DF)) m = steer ? 3'd3 : 3'd4;
      else m = 3'd4;
    end else begin
      if (a >= 32'hA0000 && a <= 32'hBFFFF) m = steer ? 3'd3 : 3'd4;
      else if (a < TOM) m = 3'd1;
      else if (a >= AP_BASE && a <= AP_LIM) m = 3'd2;
      else m = 3'd4;
    end
    case (src)
      2'd0, 2'd2: acc = 1'b1;
      2'd1:       acc = !io && (m == 3'd1 || m == 3'd2 || m == 3'd3);
      default:    acc = 1'b0;
    endcase
    t = acc ? m : 3'd0;
  endfunction

  // Driver: called at a falling edge; returns at the falling edge after acceptance.
  task automatic sendReq(input logic [1:0] src, input logic io, input logic [31:0] a, input string tag);
    logic [2:0] eT;
    logic       eA;
    model(src, io, a, cfgVgaToGfx, eT, eA);
    reqSrc = src; reqIsIo = io; reqAddr = a; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    expTgt.push_back(eT); expAcc.push_back(eA); expTag.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b1, "R9 result visible after accept", int'(rspValid), 1);
  endtask

  // Monitor: compares each taken result with the scoreboard head.
  always @(negedge clk) begin
    if (rstN && rspValid && rspReady) begin
      if (expTgt.size() == 0) begin
        check(1'b0, "R9 unexpected result", int'(rspTarget), -1);
      end else begin
        logic [2:0] t;
        logic a;
        string g;
        t = expTgt.pop_front(); a = expAcc.pop_front(); g = expTag.pop_front();
        check(rspTarget == t && rspAccept == a, g, int'({rspTarget, rspAccept}), int'({t, a}));
      end
    end
  end

  task automatic drain();
    while (expTgt.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sweepHost(input logic [1:0] src);
    sendReq(src, 1'b0, 32'h0000_1000, "R7 sys low");
    sendReq(src, 1'b0, 32'h0009_FFFF, "R7 below window");
    sendReq(src, 1'b0, 32'h000A_0000, "R1 window low");
    sendReq(src, 1'b0, 32'h000B_FFFF, "R1 window high");
    sendReq(src, 1'b0, 32'h000C_0000, "R7 above window");
    sendReq(src, 1'b0, TOM - 1, "R7 last sys");
    sendReq(src, 1'b0, TOM, "R7 first above tom");
    sendReq(src, 1'b0, AP_BASE - 1, "R7 below aperture");
    sendReq(src, 1'b0, AP_BASE, "R7 aperture base");
    sendReq(src, 1'b0, AP_LIM, "R7 aperture limit");
    sendReq(src, 1'b0, AP_LIM + 1, "R7 above aperture");
    sendReq(src, 1'b1, 32'h0000_03B0, "R2 mono low");
    sendReq(src, 1'b1, 32'h0000_03BB, "R2 mono high");
    sendReq(src, 1'b1, 32'h0000_03BC, "R3 past mono");
    sendReq(src, 1'b1, 32'h0000_03AF, "R3 before mono");
    sendReq(src, 1'b1, 32'h0000_03BF, "R4 pinned port");
    sendReq(src, 1'b1, 32'h0000_07BF, "R4 pinned alias");
    sendReq(src, 1'b1, 32'h0000_03C0, "R2 color low");
    sendReq(src, 1'b1, 32'h0000_03DF, "R2 color high");
    sendReq(src, 1'b1, 32'h0000_03E0, "R3 past color");
    sendReq(src, 1'b1, 32'h0000_FC3B0, "R2 alias mono");
    sendReq(src, 1'b1, 32'h0000_17C0, "R2 alias color");
    sendReq(src, 1'b1, 32'h0000_0CF8, "R3 other port");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R9 reset no result", int'(rspValid), 0);
    check(reqReady == 1'b1, "R10 reset ready", int'(reqReady), 1);

    for (int s = 0; s < 2; s++) begin
      cfgVgaToGfx = (s == 0);
      sweepHost(2'd0);
      sweepHost(2'd2);   // R8 same map for graphics source
      // hub source filter
      sendReq(2'd1, 1'b1, 32'h0000_03C0, "R5 hub io display");
      sendReq(2'd1, 1'b1, 32'h0000_03BF, "R5 hub io pinned");
      sendReq(2'd1, 1'b0, 32'h0000_2000, "R6 hub sys");
      sendReq(2'd1, 1'b0, AP_BASE + 32'h100, "R6 hub aperture");
      sendReq(2'd1, 1'b0, 32'h000A_8000, "R6 hub display window");
      sendReq(2'd1, 1'b0, TOM, "R6 hub pci memory");
      sendReq(2'd3, 1'b0, 32'h0000_2000, "R8 reserved source");
      sendReq(2'd3, 1'b1, 32'h0000_03C0, "R8 reserved io");
      drain();
    end

    // Fill all slots with the result side held off.
    cfgVgaToGfx = 1'b1;
    hold = 1'b1;
    @(negedge clk);
    sendReq(2'd0, 1'b0, 32'h000A_0000, "R10 fill one");
    sendReq(2'd1, 1'b1, 32'h0000_03B4, "R10 fill two");
    sendReq(2'd2, 1'b0, AP_BASE, "R10 fill three");
    sendReq(2'd0, 1'b1, 32'h0000_03BF, "R10 fill four");
    check(reqReady == 1'b0, "R10 ready low when full", int'(reqReady), 0);
    begin
      logic [2:0] t0;
      t0 = rspTarget;
      check(t0 == 3'd3, "R11 head is oldest", int'(t0), 3);
      repeat (3) @(negedge clk);
      check(rspTarget == t0 && rspValid == 1'b1, "R11 head held", int'(rspTarget), int'(t0));
      check(reqReady == 1'b0, "R10 still stalled", int'(reqReady), 0);
    end
    hold = 1'b0;
    sendReq(2'd0, 1'b0, 32'h0000_0040, "R9 order after stall");
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule